// File: doc/BRIEF.md
# Shadow-Backed Byte RAM with Store/Recall Control

This block is a synchronous byte-wide static RAM in which every word has a nonvolatile shadow copy. A controller moves data between the two arrays. A STORE copies the whole working array into the shadow array. A RECALL rebuilds the working array from the shadow array. Analog storage behaviour is not modelled, and transfer durations are counted in clock cycles set by parameters.

In normal mode the host reads and writes the working array through chip select, write enable and output enable. A transfer can be started in several ways:
- a rising power-fail indication;
- a falling edge on the active-low hardware store request;
- a rising power-good indication;
- one of two six-read command sequences issued over the host port.

While a transfer runs, the block drives its active-low busy output and ignores all host traffic. At chip level, busy and the store request share one open-drain pin; here they are modelled as separate input and output.

The host port has no back-pressure. Each access completes in one cycle, or it is silently dropped while busy. The host must watch `busy_n` and hold off, because nothing is retried. Read data is returned one cycle after the read, together with `rdata_en`. When `rdata_en` is 0, the data bus is released and reads as zero.

Top module: `nvs_ctrl`

## Requirements
- R1: With busy inactive, a cycle with `cs`=1 and `we`=1 writes `wdata` to `addr`. A cycle with `cs`=1, `we`=0 and `oe`=1 returns that word on `rdata` with `rdata_en`=1 in the next cycle. With `oe`=0 the read returns `rdata_en`=0, and with `cs`=0 nothing is written.
- R2: The working and shadow arrays each hold 2^`ADDR_W` words of `DATA_W` bits. Setting `ADDR_W`=13 gives 8192 bytes.
- R3: Six successive accepted reads start a STORE when their addresses are entries 0 to 5 of `STORE_SEQ`, where entry k sits at bits [k*ADDR_W +: ADDR_W]. The transfer begins in the cycle after the sixth read, and that sixth read returns `rdata_en`=0. Cycles with `cs`=0 do not affect the sequence.
- R4: An accepted write, or an accepted read of any address other than the expected one, returns detection to step 0 without counting as a step. An aborted sequence starts no transfer.
- R5: The RECALL sequence equals the STORE sequence except that its sixth address is `RECALL_LAST`.
- R6: A falling edge of `store_req_n` or a rising edge of `pwr_fail`, seen while idle, starts a STORE in the next cycle.
- R7: A rising edge of `pwr_good` seen while idle starts a RECALL. After reset, a `pwr_good` that is already high counts as a rising edge.
- R8: `busy_n` is 0 for exactly `STORE_CYC` cycles for a STORE and exactly `RECALL_CYC` cycles for a RECALL, and is 1 otherwise.
- R9: While `busy_n`=0, host writes have no effect, reads return `rdata_en`=0, the command sequence does not advance, and trigger edges are discarded.
- R10: A STORE copies every working word into the shadow array at the end of its count. Later host writes do not alter the shadow copy.
- R11: A RECALL first clears every working word to zero (during the first `RECALL_CYC`/2 cycles) and then loads every word from the shadow array. The shadow array is never modified, so repeated RECALLs give identical data.
- R12: When several requests arrive in the same idle cycle, one transfer starts, in this priority: power-fail, store pin, software STORE, power-good, software RECALL. The losing request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for a host access |
| we | input | 1 | 1 = write, 0 = read |
| oe | input | 1 | Read output enable |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, zero when not enabled |
| rdata_en | output | 1 | Read data is driven this cycle |
| pwr_fail | input | 1 | Power-fail indication, rising edge requests a STORE |
| pwr_good | input | 1 | Power-good indication, rising edge requests a RECALL |
| store_req_n | input | 1 | Hardware store request, falling edge requests a STORE |
| busy_n | output | 1 | Active-low busy while a transfer runs |

## Verification
The sharpest overlap is a software command sequence completing in the same cycle as a power edge. The bench provokes it twice. In the first case, the sixth STORE read coincides with a `pwr_good` rise. In the second, the sixth RECALL read coincides with a `pwr_fail` rise. Each case is judged by the busy length, which must equal `STORE_CYC`, then by a quiet interval that shows the losing recall never ran, and finally by a later recall that proves which data reached the shadow array.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_STORE = 2'd1,
    XF_CLEAR = 2'd2,
    XF_LOAD  = 2'd3
  } xf_state_e;

  typedef enum logic [1:0] {
    SW_NONE   = 2'd0,
    SW_STORE  = 2'd1,
    SW_RECALL = 2'd2
  } sw_cmd_e;

  typedef struct packed {
    logic store;
    logic recall;
  } xf_req_t;

endpackage

// File: rtl/nvs_seq_detect.sv
module nvs_seq_detect
  import nvs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int SEQ_LEN = 6,
  parameter int STEP_W  = 3,
  parameter logic [SEQ_LEN*ADDR_W-1:0] STORE_SEQ = '0,
  parameter logic [ADDR_W-1:0] RECALL_LAST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] addr,
  output sw_cmd_e           cmd,
  output logic [STEP_W-1:0] step
);

  localparam int LAST = SEQ_LEN - 1;

  logic [ADDR_W-1:0] want [SEQ_LEN];
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_d;
  logic              at_last;
  logic              hit;

  for (genvar g = 0; g < SEQ_LEN; g++) begin : g_want
    assign want[g] = STORE_SEQ[g*ADDR_W +: ADDR_W];
  end

  always_comb begin
    at_last = (step_q == STEP_W'(LAST));
    hit     = acc_rd && (addr == want[step_q]);
    cmd     = SW_NONE;
    if (acc_rd && at_last) begin
      if (addr == want[LAST])        cmd = SW_STORE;
      else if (addr == RECALL_LAST)  cmd = SW_RECALL;
    end
    step_d = step_q;
    if (acc_rd || acc_wr) begin
      if (hit && !at_last) step_d = step_q + STEP_W'(1);
      else                 step_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  assign step = step_q;

endmodule

// File: rtl/nvs_xfer_fsm.sv
module nvs_xfer_fsm
  import nvs_pkg::*;
#(
  parameter int STORE_CYC  = 64,
  parameter int RECALL_CYC = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pwr_fail,
  input  logic      pwr_good,
  input  logic      store_req_n,
  input  sw_cmd_e   sw_cmd,
  output xf_state_e state,
  output logic      busy,
  output logic      fire_store,
  output logic      fire_clear,
  output logic      fire_load
);

  localparam int CLR_CYC  = RECALL_CYC / 2;
  localparam int LOAD_CYC = RECALL_CYC - CLR_CYC;
  localparam int MAX_CYC  = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  xf_state_e  state_q;
  logic [CNT_W-1:0] cnt_q;
  logic       pf_q, pg_q, pin_q;
  logic       pf_edge, pg_edge, pin_edge;
  logic       cnt_zero;
  xf_req_t    req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_q  <= 1'b0;
      pg_q  <= 1'b0;
      pin_q <= 1'b1;
    end else begin
      pf_q  <= pwr_fail;
      pg_q  <= pwr_good;
      pin_q <= store_req_n;
    end
  end

  always_comb begin
    pf_edge    = pwr_fail & ~pf_q;
    pg_edge    = pwr_good & ~pg_q;
    pin_edge   = ~store_req_n & pin_q;
    req.store  = pf_edge | pin_edge | (sw_cmd == SW_STORE);
    req.recall = pg_edge | (sw_cmd == SW_RECALL);
    cnt_zero   = (cnt_q == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= XF_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        XF_IDLE: begin
          if (req.store) begin
            state_q <= XF_STORE;
            cnt_q   <= CNT_W'(STORE_CYC - 1);
          end else if (req.recall) begin
            state_q <= XF_CLEAR;
            cnt_q   <= CNT_W'(CLR_CYC - 1);
          end
        end
        XF_STORE: begin
          if (cnt_zero) state_q <= XF_IDLE;
          else          cnt_q   <= cnt_q - CNT_W'(1);
        end
        XF_CLEAR: begin
          if (cnt_zero) begin
            state_q <= XF_LOAD;
            cnt_q   <= CNT_W'(LOAD_CYC - 1);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        XF_LOAD: begin
          if (cnt_zero) state_q <= XF_IDLE;
          else          cnt_q   <= cnt_q - CNT_W'(1);
        end
        default: state_q <= XF_IDLE;
      endcase
    end
  end

  assign state      = state_q;
  assign busy       = (state_q != XF_IDLE);
  assign fire_store = (state_q == XF_STORE) && cnt_zero;
  assign fire_clear = (state_q == XF_CLEAR) && cnt_zero;
  assign fire_load  = (state_q == XF_LOAD)  && cnt_zero;

endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              bulk_store,
  input  logic              bulk_clear,
  input  logic              bulk_load,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] work_q   [DEPTH];
  logic [DATA_W-1:0] shadow_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (bulk_clear)     work_q[i] <= '0;
      else if (bulk_load) work_q[i] <= shadow_q[i];
    end
    if (wr_en && !bulk_clear && !bulk_load) work_q[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (bulk_store) begin
      for (int i = 0; i < DEPTH; i++) shadow_q[i] <= work_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata_q <= work_q[addr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int SEQ_LEN    = 6,
  parameter logic [SEQ_LEN*ADDR_W-1:0] STORE_SEQ = 48'h4D963AC5710E,
  parameter logic [ADDR_W-1:0] RECALL_LAST = 8'hB2,
  parameter int STORE_CYC  = 64,
  parameter int RECALL_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_en,
  input  logic              pwr_fail,
  input  logic              pwr_good,
  input  logic              store_req_n,
  output logic              busy_n
);

  localparam int STEP_W = $clog2(SEQ_LEN);

  xf_state_e         xf_state;
  sw_cmd_e           sw_cmd;
  logic [STEP_W-1:0] seq_step;
  logic              busy;
  logic              acc_rd, acc_wr;
  logic              fire_store, fire_clear, fire_load;
  logic              drive_q;
  logic [DATA_W-1:0] arr_rdata;

  assign acc_wr = cs & ~busy & we;
  assign acc_rd = cs & ~busy & ~we;

  nvs_seq_detect #(
    .ADDR_W      (ADDR_W),
    .SEQ_LEN     (SEQ_LEN),
    .STEP_W      (STEP_W),
    .STORE_SEQ   (STORE_SEQ),
    .RECALL_LAST (RECALL_LAST)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_rd (acc_rd),
    .acc_wr (acc_wr),
    .addr   (addr),
    .cmd    (sw_cmd),
    .step   (seq_step)
  );

  nvs_xfer_fsm #(
    .STORE_CYC  (STORE_CYC),
    .RECALL_CYC (RECALL_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_fail    (pwr_fail),
    .pwr_good    (pwr_good),
    .store_req_n (store_req_n),
    .sw_cmd      (sw_cmd),
    .state       (xf_state),
    .busy        (busy),
    .fire_store  (fire_store),
    .fire_clear  (fire_clear),
    .fire_load   (fire_load)
  );

  nvs_arrays #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_arr (
    .clk        (clk),
    .wr_en      (acc_wr),
    .rd_en      (acc_rd),
    .addr       (addr),
    .wdata      (wdata),
    .bulk_store (fire_store),
    .bulk_clear (fire_clear),
    .bulk_load  (fire_load),
    .rdata      (arr_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) drive_q <= 1'b0;
    else        drive_q <= acc_rd & oe;
  end

  assign rdata_en = drive_q & ~busy;
  assign rdata    = rdata_en ? arr_rdata : '0;
  assign busy_n   = ~busy;

endmodule

// File: rtl/nvs_ctrl_chk.sv
module nvs_ctrl_chk
  import nvs_pkg::*;
#(
  parameter int STORE_CYC  = 64,
  parameter int RECALL_CYC = 8,
  parameter int SEQ_LEN    = 6,
  parameter int STEP_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_n,
  input logic              rdata_en,
  input logic              pwr_fail,
  input logic              store_req_n,
  input xf_state_e         state,
  input logic [STEP_W-1:0] step
);

  int run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)       run_len <= 0;
    else if (!busy_n) run_len <= run_len + 1;
    else              run_len <= 0;
  end

  AST_XFER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> (run_len == STORE_CYC || run_len == RECALL_CYC)); // R8

  AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |=> !rdata_en); // R9

  AST_CLEAR_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XF_LOAD && $past(state) != XF_LOAD) |-> $past(state) == XF_CLEAR); // R11

  AST_PF_STARTS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XF_IDLE && pwr_fail && !$past(pwr_fail)) |=> state == XF_STORE); // R6

  AST_PIN_STARTS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XF_IDLE && !store_req_n && $past(store_req_n)) |=> state == XF_STORE); // R6

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(step) < SEQ_LEN); // R4

endmodule

bind nvs_ctrl nvs_ctrl_chk #(
  .STORE_CYC  (STORE_CYC),
  .RECALL_CYC (RECALL_CYC),
  .SEQ_LEN    (SEQ_LEN),
  .STEP_W     (STEP_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_n      (busy_n),
  .rdata_en    (rdata_en),
  .pwr_fail    (pwr_fail),
  .store_req_n (store_req_n),
  .state       (xf_state),
  .step        (seq_step)
);

// File: tb/nvs_ctrl_tb.sv
module nvs_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 4;
  localparam int DW   = 8;
  localparam int NW   = 1 << AW;
  localparam int SCYC = 12;
  localparam int RCYC = 6;
  localparam logic [AW-1:0] RLAST = 4'd6;
  localparam logic [AW-1:0] SSEQ [6] = '{4'd3, 4'd12, 4'd5, 4'd10, 4'd0, 4'd15};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, we = 1'b0, oe = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_en;
  logic pwr_fail = 1'b0, pwr_good = 1'b0, store_req_n = 1'b1;
  logic busy_n;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvs_ctrl #(
    .ADDR_W      (AW),
    .DATA_W      (DW),
    .SEQ_LEN     (6),
    .STORE_SEQ   ({4'd15, 4'd0, 4'd10, 4'd5, 4'd12, 4'd3}),
    .RECALL_LAST (RLAST),
    .STORE_CYC   (SCYC),
    .RECALL_CYC  (RCYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .oe(oe), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en), .pwr_fail(pwr_fail),
    .pwr_good(pwr_good), .store_req_n(store_req_n), .busy_n(busy_n)
  );

  function automatic logic [DW-1:0] pat_f(int a);
    return DW'((a * 37 + 5) & 8'hFF);
  endfunction
  function automatic logic [DW-1:0] pat_g(int a);
    return DW'((a * 11) ^ 8'h5A);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic host_write(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic host_read(input int a, output logic [DW-1:0] d, output logic en);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; oe = 1'b1; addr = AW'(a);
    @(negedge clk);
    cs = 1'b0;
    d = rdata; en = rdata_en;
  endtask

  task automatic measure_busy(output int n);
    n = 0;
    while (!busy_n && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic quiet(input string tag, input int cyc);
    int lows = 0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (!busy_n) lows++;
    end
    chk(tag, lows, 0);
  endtask

  task automatic fill(input bit use_f);
    for (int a = 0; a < NW; a++) host_write(a, use_f ? pat_f(a) : pat_g(a));
  endtask

  task automatic check_all(input string tag, input bit use_f);
    logic [DW-1:0] d;
    logic en;
    for (int a = 0; a < NW; a++) begin
      host_read(a, d, en);
      chk({tag, " enable"}, en, 1);
      chk({tag, " data"}, d, use_f ? pat_f(a) : pat_g(a));
    end
  endtask

  task automatic seq_head(input int upto);
    logic [DW-1:0] d;
    logic en;
    for (int k = 0; k < upto; k++) host_read(SSEQ[k], d, en);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 200000 cycles expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic en;
    int n;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset busy_n", busy_n, 1);
    chk("R1 reset rdata_en", rdata_en, 0);

    // R1 R2: sweep every word
    fill(1'b1);
    @(negedge clk);
    cs = 1'b0; we = 1'b1; addr = 4'd4; wdata = ~pat_f(4);
    @(negedge clk);
    we = 1'b0;
    check_all("R1 sweep f", 1'b1);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; oe = 1'b0; addr = 4'd7;
    @(negedge clk);
    cs = 1'b0; oe = 1'b1;
    chk("R1 oe low no drive", rdata_en, 0);

    // R3: software STORE
    seq_head(5);
    host_read(SSEQ[5], d, en);
    chk("R3 completing read undriven", en, 0);
    measure_busy(n);
    chk("R3 R8 store length", n, SCYC);

    // R5 R10 R11: overwrite then software RECALL
    fill(1'b0);
    check_all("R10 work g", 1'b0);
    seq_head(5);
    host_read(RLAST, d, en);
    measure_busy(n);
    chk("R5 R8 recall length", n, RCYC);
    check_all("R11 recall f", 1'b1);

    // R7 R11: power-good recall returns identical data
    fill(1'b0);
    @(negedge clk);
    pwr_good = 1'b1;
    @(negedge clk);
    measure_busy(n);
    chk("R7 pwr_good recall length", n, RCYC);
    check_all("R11 repeat recall f", 1'b1);
    pwr_good = 1'b0;

    // R4: abort by mismatched read
    seq_head(3);
    host_read(7, d, en);
    chk("R4 interloper read data", d, pat_f(7));
    for (int k = 3; k < 6; k++) host_read(SSEQ[k], d, en);
    chk("R4 abort read last drives", en, 1);
    quiet("R4 abort by read", 4);

    // R4: abort by write
    seq_head(4);
    host_write(1, pat_f(1));
    for (int k = 4; k < 6; k++) host_read(SSEQ[k], d, en);
    chk("R4 abort write last drives", en, 1);
    quiet("R4 abort by write", 4);

    // R6 R9: pin store, host traffic and edges while busy are ignored
    fill(1'b0);
    @(negedge clk);
    store_req_n = 1'b0;
    @(negedge clk);
    store_req_n = 1'b1;
    n = 0;
    while (!busy_n && n < 5000) begin
      n++;
      chk("R9 no drive while busy", rdata_en, 0);
      cs = 1'b0; we = 1'b0;
      if (n == 2) begin
        cs = 1'b1; we = 1'b1; addr = 4'd2; wdata = 8'hAA; pwr_good = 1'b1;
      end else if (n == 3) begin
        cs = 1'b1; we = 1'b0; oe = 1'b1; addr = 4'd5;
      end
      @(negedge clk);
    end
    cs = 1'b0; we = 1'b0;
    chk("R6 R8 pin store length", n, SCYC);
    chk("R9 read during busy undriven", rdata_en, 0);
    quiet("R9 pwr_good edge lost", 4);
    check_all("R9 write ignored", 1'b0);
    pwr_good = 1'b0;

    // R6 R10: power-fail store snapshots g; later writes do not reach shadow
    @(negedge clk);
    pwr_fail = 1'b1;
    @(negedge clk);
    measure_busy(n);
    chk("R6 pwr_fail store length", n, SCYC);
    pwr_fail = 1'b0;
    fill(1'b1);
    seq_head(5);
    host_read(RLAST, d, en);
    measure_busy(n);
    chk("R10 recall length", n, RCYC);
    check_all("R10 shadow snapshot g", 1'b0);

    // R12: software STORE completion and pwr_good rise in one cycle
    fill(1'b1);
    seq_head(5);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; oe = 1'b1; addr = SSEQ[5]; pwr_good = 1'b1;
    @(negedge clk);
    cs = 1'b0;
    measure_busy(n);
    chk("R12 store beats pwr_good", n, SCYC);
    quiet("R12 recall dropped", 4);
    pwr_good = 1'b0;
    fill(1'b0);
    seq_head(5);
    host_read(RLAST, d, en);
    measure_busy(n);
    check_all("R12 store took effect", 1'b1);

    // R12: software RECALL completion and pwr_fail rise in one cycle
    fill(1'b0);
    seq_head(5);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; oe = 1'b1; addr = RLAST; pwr_fail = 1'b1;
    @(negedge clk);
    cs = 1'b0;
    measure_busy(n);
    chk("R12 pwr_fail beats recall", n, SCYC);
    pwr_fail = 1'b0;
    check_all("R12 work untouched", 1'b0);
    fill(1'b1);
    seq_head(5);
    host_read(RLAST, d, en);
    measure_busy(n);
    check_all("R12 shadow holds g", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule